// File: doc/BRIEF.md
# PS/2 Host Port Register Front End

This block is the register face of a PS/2 keyboard or mouse port. A processor reaches it through a simple word-addressed bus over a 4 KB window. The block keeps a control register, a clock-divisor register and a copy of the byte most recently taken from the receive side. From these it builds a status word with a parity flag, drives one interrupt line, and returns a fixed set of identification bytes at the top of the window.

The serial line engine sits on the device side. It presents a received byte together with a pending flag. The block answers with a one-cycle pop strobe when software reads a pending byte. Software writes to the data register are passed to the line engine as a byte and a one-cycle write strobe. The serial timing and the use of the divisor value belong to that engine, not to this block.

Read data is registered. An access in cycle N shows its result on `bus_rdata` from cycle N+1 until the next read. Device-side strobes are asserted in the access cycle itself.

Top module: `kbms_regif`

## Requirements
- R1: After reset the control, divisor and held-byte registers are 0, `irq` is low and `bus_rdata` is 0.
- R2: Registers are selected by byte offset divided by 4: index 0 is control, 1 status, 2 data, 3 divisor, 4 interrupt status. The result of a read appears on `bus_rdata` in the cycle after the access. Control and divisor read back the written value, truncated to their widths (8 and 8 bits by default) and zero-extended.
- R3: The status word has bit 6 (transmit empty) always 1, bit 4 (receive full) equal to `rx_pending`, bit 2 as in R4, and every other bit 0.
- R4: Status bit 2 is the XOR of all 8 bits of the held byte, which is the byte most recently taken by a data read.
- R5: `irq` is high exactly when (`rx_pending` and control bit 4) or control bit 3. A control write changes `irq` from the next cycle on.
- R6: A data read while `rx_pending` is high pulses `rx_pop` for that one cycle and loads `rx_byte` into the held byte. A data read with nothing pending leaves `rx_pop` low. Either read returns the held byte after the access, so a read with nothing pending repeats the previous value.
- R7: Reading the interrupt-status register returns `rx_pending` in bit 0, 1 in bit 1 and 0 elsewhere.
- R8: Offsets 0xFE0, 0xFE4, …, 0xFFC return in turn 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R9: A data-register write pulses `tx_write` for one cycle with `tx_byte` equal to the write's low byte. A divisor write only stores its value and leaves `irq` unchanged.
- R10: Reads of any offset other than the above return 0. Writes to status, interrupt status or any unmapped offset change no register, do not pulse `tx_write` and do not change `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |
| rx_pending | input | 1 | Received byte waiting on device side |
| rx_byte | input | 8 | Waiting received byte |
| rx_pop | output | 1 | One-cycle take strobe for the waiting byte |
| tx_byte | output | 8 | Byte to transmit |
| tx_write | output | 1 | One-cycle transmit strobe |

## Verification
A corrupted held byte is visible in two ways. The parity flag in the very next status read is wrong, and so is the value repeated by a data read with nothing pending. A stale or wrongly loaded control register shows on `irq` in the cycle after the control write and stays visible until it is rewritten. Decode faults show as a wrong word, one cycle after the offending read, or as a stray `tx_write`/`rx_pop` in the access cycle itself. For this reason every read is compared against a queued expectation, and the strobes are sampled during the access.

// File: rtl/kbms_pkg.sv
package kbms_pkg;
    localparam int WIN_AW = 12;
    localparam int BYTE_W = 8;

    // status word bit positions
    localparam int ST_TXEMPTY = 6;
    localparam int ST_RXFULL  = 4;
    localparam int ST_PARITY  = 2;

    // control bits feeding the interrupt
    localparam int CB_FORCE = 3;
    localparam int CB_RXIE  = 4;

    typedef enum logic [2:0] {
        RG_CTRL,
        RG_STAT,
        RG_DATA,
        RG_DIV,
        RG_IRQ,
        RG_ID,
        RG_NONE
    } region_t;
endpackage

// File: rtl/kbms_decode.sv
module kbms_decode
    import kbms_pkg::*;
(
    input  logic [WIN_AW-1:0] addr,
    output region_t           region,
    output logic [2:0]        id_idx
);
    always_comb begin
        id_idx = addr[4:2];
        if (addr[WIN_AW-1:5] == 7'h7F) begin
            region = RG_ID;
        end else begin
            case (addr[WIN_AW-1:2])
                10'd0:   region = RG_CTRL;
                10'd1:   region = RG_STAT;
                10'd2:   region = RG_DATA;
                10'd3:   region = RG_DIV;
                10'd4:   region = RG_IRQ;
                default: region = RG_NONE;
            endcase
        end
    end
endmodule

// File: rtl/kbms_idrom.sv
module kbms_idrom
    import kbms_pkg::*;
(
    input  logic [2:0]        idx,
    output logic [BYTE_W-1:0] id_byte
);
    always_comb begin
        case (idx)
            3'd0:    id_byte = 8'h50;
            3'd1:    id_byte = 8'h10;
            3'd2:    id_byte = 8'h04;
            3'd3:    id_byte = 8'h00;
            3'd4:    id_byte = 8'h0D;
            3'd5:    id_byte = 8'hF0;
            3'd6:    id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    end
endmodule

// File: rtl/kbms_parity.sv
module kbms_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] din,
    output logic         odd
);
    logic [W:0] acc;
    assign acc[0] = 1'b0;
    for (genvar gi = 0; gi < W; gi++) begin : g_chain
        assign acc[gi+1] = acc[gi] ^ din[gi];
    end
    assign odd = acc[W];
endmodule

// File: rtl/kbms_regif.sv
module kbms_regif
    import kbms_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CTRL_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [WIN_AW-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                irq,
    input  logic                rx_pending,
    input  logic [BYTE_W-1:0]   rx_byte,
    output logic                rx_pop,
    output logic [BYTE_W-1:0]   tx_byte,
    output logic                tx_write
);
    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [DIV_W-1:0]  div;
        logic [BYTE_W-1:0] last;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t regs_d, regs_q;

    region_t           region;
    logic [2:0]        id_idx;
    logic [BYTE_W-1:0] id_byte;
    logic              last_odd;
    logic              rd_en, wr_en;
    logic [DATA_W-1:0] stat_word, irqs_word;

    kbms_decode u_dec (
        .addr   (bus_addr),
        .region (region),
        .id_idx (id_idx)
    );

    kbms_idrom u_id (
        .idx     (id_idx),
        .id_byte (id_byte)
    );

    kbms_parity #(.W(BYTE_W)) u_par (
        .din (regs_q.last),
        .odd (last_odd)
    );

    assign rd_en = bus_sel & ~bus_wr;
    assign wr_en = bus_sel & bus_wr;

    always_comb begin
        stat_word              = '0;
        stat_word[ST_TXEMPTY]  = 1'b1;
        stat_word[ST_RXFULL]   = rx_pending;
        stat_word[ST_PARITY]   = last_odd;
        irqs_word              = '0;
        irqs_word[1]           = 1'b1;
        irqs_word[0]           = rx_pending;
    end

    always_comb begin
        regs_d   = regs_q;
        rx_pop   = 1'b0;
        tx_write = 1'b0;
        tx_byte  = bus_wdata[BYTE_W-1:0];

        if (wr_en) begin
            case (region)
                RG_CTRL: regs_d.ctrl = bus_wdata[CTRL_W-1:0];
                RG_DIV:  regs_d.div  = bus_wdata[DIV_W-1:0];
                RG_DATA: tx_write    = 1'b1;
                default: ;
            endcase
        end

        if (rd_en) begin
            case (region)
                RG_CTRL: regs_d.rdata = DATA_W'(regs_q.ctrl);
                RG_STAT: regs_d.rdata = stat_word;
                RG_DATA: begin
                    if (rx_pending) begin
                        rx_pop      = 1'b1;
                        regs_d.last = rx_byte;
                    end
                    regs_d.rdata = DATA_W'(regs_d.last);
                end
                RG_DIV:  regs_d.rdata = DATA_W'(regs_q.div);
                RG_IRQ:  regs_d.rdata = irqs_word;
                RG_ID:   regs_d.rdata = DATA_W'(id_byte);
                default: regs_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign bus_rdata = regs_q.rdata;
    assign irq       = (rx_pending & regs_q.ctrl[CB_RXIE]) | regs_q.ctrl[CB_FORCE];
endmodule

// File: rtl/kbms_regif_chk.sv
module kbms_regif_chk
    import kbms_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [WIN_AW-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic              rx_pending,
    input logic [BYTE_W-1:0] rx_byte,
    input logic              rx_pop,
    input logic              tx_write
);
    logic rd_word1, rd_word4, wr_ctrl;
    assign rd_word1 = bus_sel && !bus_wr && (bus_addr[WIN_AW-1:2] == 10'd1);
    assign rd_word4 = bus_sel && !bus_wr && (bus_addr[WIN_AW-1:2] == 10'd4);
    assign wr_ctrl  = bus_sel && bus_wr && (bus_addr[WIN_AW-1:2] == 10'd0);

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!irq && bus_rdata == '0);
        end
    end

    p_txempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_word1 |=> bus_rdata[ST_TXEMPTY]);

    p_force_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[CB_FORCE]) |=> irq);

    p_pop_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> (rx_pending && bus_sel && !bus_wr));

    p_pop_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |=> (bus_rdata[BYTE_W-1:0] == $past(rx_byte)));

    p_irqstat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_word4 |=> (bus_rdata[1] && bus_rdata[0] == $past(rx_pending)));

    p_tx_on_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_write |-> (bus_sel && bus_wr));
endmodule

bind kbms_regif kbms_regif_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq        (irq),
    .rx_pending (rx_pending),
    .rx_byte    (rx_byte),
    .rx_pop     (rx_pop),
    .tx_write   (tx_write)
);

// File: tb/kbms_regif_test.sv
`timescale 1ns/1ps
module kbms_regif_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        rx_pending = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_pop;
    logic [7:0]  tx_byte;
    logic        tx_write;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    kbms_regif uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .rx_pending(rx_pending), .rx_byte(rx_byte),
        .rx_pop(rx_pop), .tx_byte(tx_byte), .tx_write(tx_write)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: each read's result is compared one edge after the access
    always @(posedge clk) begin
        if (rst_n && bus_sel && !bus_wr) begin
            #1;
            if (exp_q.size() == 0) begin
                chk(1'b0, "scoreboard underflow", bus_rdata, '0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(bus_rdata == e, t, bus_rdata, e);
            end
        end
    end

    task automatic bus_read(input logic [11:0] a, input logic [31:0] e, input string t,
                            input bit exp_pop);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        #0.5;
        chk(rx_pop == exp_pop, {t, " rx_pop"}, 32'(rx_pop), 32'(exp_pop));
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input bit exp_tx,
                             input string t);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        #0.5;
        chk(tx_write == exp_tx, {t, " tx_write"}, 32'(tx_write), 32'(exp_tx));
        if (exp_tx) chk(tx_byte == d[7:0], {t, " tx_byte"}, 32'(tx_byte), 32'(d[7:0]));
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic chk_irq(input bit e, input string t);
        #0.5;
        chk(irq == e, t, 32'(irq), 32'(e));
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", '0, '0);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(irq == 1'b0, "R1 irq in reset", 32'(irq), 0);
        chk(bus_rdata == 0, "R1 rdata in reset", bus_rdata, 0);
        rst_n = 1'b1;

        bus_read(12'h000, 32'h0, "R1 ctrl after reset", 0);
        bus_read(12'h00C, 32'h0, "R1 div after reset", 0);
        bus_read(12'h004, 32'h40, "R3 status idle", 0);

        // interrupt paths
        bus_write(12'h000, 32'h08, 0, "R5 force");
        chk_irq(1, "R5 forced irq high");
        bus_read(12'h000, 32'h08, "R2 ctrl readback", 0);
        bus_write(12'h000, 32'h10, 0, "R5 rxie");
        chk_irq(0, "R5 rxie no pending");
        rx_pending = 1'b1;
        chk_irq(1, "R5 rxie with pending");
        bus_write(12'h000, 32'h1E7, 0, "R2 ctrl trunc");
        chk_irq(0, "R5 both bits clear");
        bus_read(12'h000, 32'hE7, "R2 ctrl truncated", 0);

        // receive path
        bus_read(12'h004, 32'h50, "R3 status pending", 0);
        rx_byte = 8'hA7;
        bus_read(12'h008, 32'hA7, "R6 pop read", 1);
        rx_pending = 1'b0;
        bus_read(12'h004, 32'h44, "R4 odd parity A7", 0);
        bus_read(12'h008, 32'hA7, "R6 repeat no pending", 0);
        rx_pending = 1'b1; rx_byte = 8'h3C;
        bus_read(12'h008, 32'h3C, "R6 second pop", 1);
        rx_pending = 1'b0;
        bus_read(12'h004, 32'h40, "R4 even parity 3C", 0);

        // interrupt status
        bus_read(12'h010, 32'h2, "R7 irq status idle", 0);
        rx_pending = 1'b1;
        bus_read(12'h010, 32'h3, "R7 irq status pending", 0);
        rx_pending = 1'b0;

        // identification space
        begin
            logic [7:0] ids [8] = '{8'h50, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
            for (int i = 0; i < 8; i++)
                bus_read(12'hFE0 + 12'(4*i), 32'(ids[i]), "R8 id byte", 0);
        end

        // transmit and divisor
        bus_write(12'h000, 32'h08, 0, "R9 setup");
        bus_write(12'h008, 32'h123456C5, 1, "R9 data write");
        bus_write(12'h00C, 32'hABC, 0, "R9 div write");
        chk_irq(1, "R9 irq unchanged by div");
        bus_read(12'h00C, 32'hBC, "R9 div readback", 0);
        bus_read(12'h008, 32'h3C, "R9 data write leaves held byte", 0);

        // unmapped and read-only
        bus_read(12'h014, 32'h0, "R10 unmapped 0x014", 0);
        bus_read(12'h800, 32'h0, "R10 unmapped 0x800", 0);
        bus_write(12'h004, 32'hFF, 0, "R10 status write");
        bus_write(12'h010, 32'hFF, 0, "R10 irqstat write");
        bus_write(12'h020, 32'hFF, 0, "R10 unmapped write");
        chk_irq(1, "R10 irq unchanged");
        bus_read(12'h000, 32'h08, "R10 ctrl unchanged", 0);
        bus_read(12'h00C, 32'hBC, "R10 div unchanged", 0);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 0);
        done = 1'b1;
        finish_run();
    end
endmodule